// File: doc/BRIEF.md
# PCI Memory Window Address Translator

This block holds a bank of eight 32-bit control registers behind a simple word-wide register bus. It turns an offset inside one of three local memory windows into a 32-bit PCI memory address. Software writes a mapping register for each window, and the translator forms the PCI address from that register and the offset. Three more registers return the value last written to them and have no other effect. Two further registers, an identity word and a flags word, are stored and read back in the same way.

A build-time parameter picks one of two board variants. The variant fixes the three window sizes and also fixes how a mapping register is read. In variant 0, the low nibble of the mapping register supplies address bits [31:28]. In variant 1, the mapping register supplies every address bit above the window size. Translation is combinational from the stored registers. A new mapping value therefore steers the address from the cycle after the write.

Top module: `pwx_top`

## Requirements
- R1: After reset every register reads 0, the error output is low, and each window translates with a base of 0.
- R2: Offsets 0x00, 0x04 and 0x08 are the mapping registers for windows 0, 1 and 2. Offsets 0x0C and 0x10 are the identity and flags words. Offsets 0x14, 0x18 and 0x1C are the second map words 0 to 2. A read with access enable high returns the last value written to that offset.
- R3: An access to an unmapped offset reads 0 and changes no register. Unmapped means any offset with bits [1:0] not zero, or any offset of 0x20 or above.
- R4: The error output is high for exactly the one cycle after each unmapped access, and it stays low after a mapped access.
- R5: In variant 0 the window base is mapping[3:0] placed at bits [31:28]. Mapping bits [31:4] are ignored.
- R6: In variant 1 the window base is the mapping value with every bit below the window size cleared.
- R7: The offset is masked to 2^ceil(log2(size)) - 1, and the masked offset is added to the base to give a 32-bit result.
- R8: A mapping write changes the translated address starting in the cycle after the write edge. In the write cycle itself the address is unchanged.
- R9: A window index of 3 gives a translated address of 0.
- R10: The window sizes are 0x0C000000, 0x10000000 and 0x10000000 in variant 0, and 0x01000000, 0x04000000 and 0x08000000 in variant 1. An offset of size-1 passes through unchanged. An offset equal to a power-of-two size wraps to the window base.
- R11: The read data is 0 while access enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access enable |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | REG_AW | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| reg_err_o | output | 1 | One-cycle pulse after an unmapped access |
| xl_win_i | input | WIN_W | Window index |
| xl_off_i | input | 32 | Local offset inside the window |
| xl_addr_o | output | 32 | Translated PCI memory address |

## Verification
The bench builds two instances side by side, one with VARIANT 0 and one with VARIANT 1, and drives both from the same bus and translation inputs. The same mapping value therefore shows both interpretations at once. Upper mapping bits are dropped in variant 0 and the size mask is applied in variant 1. The non-power-of-two first window of variant 0 and the exact wrap at a power-of-two size are both exercised.

// File: rtl/pwx_pkg.sv
`timescale 1ns/1ps
package pwx_pkg;
  localparam int unsigned NUM_WIN = 3;
  localparam int unsigned NUM_REG = 8;
  localparam int unsigned IDX_W   = 3;

  // register slots; the order is the bus offset order (index = offset/4)
  typedef enum logic [IDX_W-1:0] {
    RS_MAP0 = 3'd0, RS_MAP1 = 3'd1, RS_MAP2 = 3'd2, RS_IDENT = 3'd3,
    RS_FLAG = 3'd4, RS_SMP0 = 3'd5, RS_SMP1 = 3'd6, RS_SMP2 = 3'd7
  } reg_slot_e;

  function automatic logic [31:0] win_size(int unsigned variant, int unsigned idx);
    if (variant == 0) begin
      return (idx == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    end
    case (idx)
      0:       return 32'h0100_0000;
      1:       return 32'h0400_0000;
      default: return 32'h0800_0000;
    endcase
  endfunction

  // 2^ceil(log2(size)) - 1
  function automatic logic [31:0] win_mask(int unsigned variant, int unsigned idx);
    logic [31:0] s;
    logic [31:0] m;
    s = win_size(variant, idx);
    m = '0;
    for (int b = 0; b < 32; b++) begin
      m[b] = ((33'd1 << b) < {1'b0, s});
    end
    return m;
  endfunction
endpackage

// File: rtl/pwx_regbank.sv
`timescale 1ns/1ps
module pwx_regbank
  import pwx_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned DW     = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  output logic                          err_o,
  output logic [NUM_WIN-1:0][DW-1:0]    map_o
);
  logic [NUM_REG-1:0][DW-1:0] regs_q;
  logic [IDX_W-1:0]           idx;
  logic                       hit;

  assign idx = addr_i[IDX_W+1:2];
  assign hit = (addr_i[1:0] == 2'b00) && ((addr_i >> (IDX_W + 2)) == '0);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      regs_q[r] <= '0;
      else if (en_i && we_i && hit && idx == IDX_W'(r)) regs_q[r] <= wdata_i;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_map
    assign map_o[w] = regs_q[int'(RS_MAP0) + w];
  end

  always_comb begin
    rdata_o = '0;
    if (en_i && hit) rdata_o = regs_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= en_i && !hit;
  end
endmodule

// File: rtl/pwx_xlat.sv
`timescale 1ns/1ps
module pwx_xlat
  import pwx_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned DW      = 32,
  parameter int unsigned WIN_W   = 2
) (
  input  logic [NUM_WIN-1:0][DW-1:0] map_i,
  input  logic [WIN_W-1:0]           win_i,
  input  logic [DW-1:0]              off_i,
  output logic [DW-1:0]              addr_o
);
  localparam int unsigned NIB_SH = DW - 4;

  logic [NUM_WIN-1:0][DW-1:0] cand;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [DW-1:0] MASK = DW'(win_mask(VARIANT, w));
    logic [DW-1:0] base;
    if (VARIANT == 0) begin : g_nib
      assign base = map_i[w] << NIB_SH;
    end else begin : g_msk
      assign base = map_i[w] & ~MASK;
    end
    assign cand[w] = base + (off_i & MASK);
  end

  always_comb begin
    addr_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_i == WIN_W'(w)) addr_o = cand[w];
    end
  end
endmodule

// File: rtl/pwx_top.sv
`timescale 1ns/1ps
module pwx_top
  import pwx_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned REG_AW  = 8,
  parameter int unsigned WIN_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_err_o,
  input  logic [WIN_W-1:0]  xl_win_i,
  input  logic [31:0]       xl_off_i,
  output logic [31:0]       xl_addr_o
);
  localparam int unsigned DW = 32;

  logic [NUM_WIN-1:0][DW-1:0] map;

  pwx_regbank #(.REG_AW(REG_AW), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (reg_en_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .err_o   (reg_err_o),
    .map_o   (map)
  );

  pwx_xlat #(.VARIANT(VARIANT), .DW(DW), .WIN_W(WIN_W)) u_xlat (
    .map_i  (map),
    .win_i  (xl_win_i),
    .off_i  (xl_off_i),
    .addr_o (xl_addr_o)
  );
endmodule

// File: rtl/pwx_chk.sv
`timescale 1ns/1ps
module pwx_chk
  import pwx_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned REG_AW  = 8,
  parameter int unsigned WIN_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_en_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              reg_err_o,
  input logic [WIN_W-1:0]  xl_win_i,
  input logic [31:0]       xl_off_i,
  input logic [31:0]       xl_addr_o
);
  logic        bad_acc;
  logic [31:0] sel_mask;

  assign bad_acc = reg_en_i && ((reg_addr_i[1:0] != 2'b00) || (32'(reg_addr_i) >= 32'h20));

  always_comb begin
    sel_mask = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (xl_win_i == WIN_W'(w)) sel_mask = win_mask(VARIANT, w);
    end
  end

  // R4
  err_after_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc |=> reg_err_o);

  // R4
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_err_o) |-> $past(bad_acc));

  // R3
  bad_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc |-> reg_rdata_o == 32'h0);

  // R11
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en_i |-> reg_rdata_o == 32'h0);

  // R9
  no_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(xl_win_i) >= NUM_WIN) |-> xl_addr_o == 32'h0);

  // R7
  offset_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(xl_win_i) < NUM_WIN) |-> ((xl_addr_o & sel_mask) == (xl_off_i & sel_mask)));
endmodule

bind pwx_top pwx_chk #(.VARIANT(VARIANT), .REG_AW(REG_AW), .WIN_W(WIN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_en_i    (reg_en_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_err_o   (reg_err_o),
  .xl_win_i    (xl_win_i),
  .xl_off_i    (xl_off_i),
  .xl_addr_o   (xl_addr_o)
);

// File: tb/pwx_top_tb.sv
`timescale 1ns/1ps
module pwx_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  win = '0;
  logic [31:0] off = '0;
  logic [31:0] rd_a, rd_b, xa_a, xa_b;
  logic        err_a, err_b;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pwx_top #(.VARIANT(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_en_i(en), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_a), .reg_err_o(err_a),
    .xl_win_i(win), .xl_off_i(off), .xl_addr_o(xa_a));

  pwx_top #(.VARIANT(1)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .reg_en_i(en), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_b), .reg_err_o(err_b),
    .xl_win_i(win), .xl_off_i(off), .xl_addr_o(xa_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a;
    #1 da = rd_a; db = rd_b;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic xl(logic [1:0] w, logic [31:0] o, logic [31:0] ea, logic [31:0] eb, string req);
    @(negedge clk);
    win = w; off = o;
    #1;
    chk({req, " v0"}, xa_a, ea);
    chk({req, " v1"}, xa_b, eb);
  endtask

  task automatic t_reset;
    logic [31:0] a, b;
    chk("R1 err v0", 32'(err_a), 0);
    chk("R1 err v1", 32'(err_b), 0);
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), a, b);
      chk("R1 reg v0", a, 0);
      chk("R1 reg v1", b, 0);
    end
    xl(2'd1, 32'h0000_0123, 32'h0000_0123, 32'h0000_0123, "R1 xlat");
    @(negedge clk);
    chk("R11 idle v0", rd_a, 0);
    chk("R11 idle v1", rd_b, 0);
  endtask

  task automatic t_regs;
    logic [31:0] a, b;
    for (int i = 0; i < 8; i++) wr(8'(i * 4), 32'hA500_0000 + 32'(i) * 32'h0101_0101);
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), a, b);
      chk("R2 readback v0", a, 32'hA500_0000 + 32'(i) * 32'h0101_0101);
      chk("R2 readback v1", b, 32'hA500_0000 + 32'(i) * 32'h0101_0101);
    end
  endtask

  task automatic t_unmapped;
    logic [31:0] a, b;
    logic [7:0] bad [3] = '{8'h20, 8'h02, 8'hFC};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      en = 1'b1; we = 1'b1; addr = bad[k]; wdata = 32'hDEAD_BEEF;
      #1 chk("R3 bad rd v0", rd_a, 0);
      @(negedge clk);
      en = 1'b0; we = 1'b0;
      chk("R4 err pulse v0", 32'(err_a), 1);
      chk("R4 err pulse v1", 32'(err_b), 1);
      @(negedge clk);
      chk("R4 err clear", 32'(err_a), 0);
    end
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), a, b);
      chk("R3 unchanged v0", a, 32'hA500_0000 + 32'(i) * 32'h0101_0101);
      chk("R3 unchanged v1", b, 32'hA500_0000 + 32'(i) * 32'h0101_0101);
    end
    @(negedge clk);
    chk("R4 no err after good", 32'(err_a), 0);
  endtask

  task automatic t_xlat;
    wr(8'h00, 32'hFFFF_FFF7);
    wr(8'h04, 32'h8ABC_DEF1);
    wr(8'h08, 32'h1357_9BDF);
    xl(2'd0, 32'h1234_5678, 32'h7234_5678, 32'hFF34_5678, "R5 R6 R7 win0");
    xl(2'd1, 32'hFFFF_FFFF, 32'h1FFF_FFFF, 32'h8BFF_FFFF, "R5 R6 R7 win1");
    xl(2'd2, 32'h0000_0010, 32'hF000_0010, 32'h1000_0010, "R5 R6 win2");
    xl(2'd3, 32'h0000_0010, 32'h0, 32'h0, "R9 no window");
  endtask

  task automatic t_timing;
    xl(2'd0, 32'h0000_0040, 32'h7000_0040, 32'hFF00_0040, "R8 before");
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'h0200_0002;
    #1;
    chk("R8 write cycle v0", xa_a, 32'h7000_0040);
    chk("R8 write cycle v1", xa_b, 32'hFF00_0040);
    @(negedge clk);
    en = 1'b0; we = 1'b0;
    chk("R8 next cycle v0", xa_a, 32'h2000_0040);
    chk("R8 next cycle v1", xa_b, 32'h0200_0040);
  endtask

  task automatic t_sizes;
    xl(2'd0, 32'h0BFF_FFFF, 32'h2BFF_FFFF, 32'h02FF_FFFF, "R10 win0 last");
    xl(2'd0, 32'h0100_0000, 32'h2100_0000, 32'h0200_0000, "R10 win0 wrap v1");
    wr(8'h08, 32'hFFFF_FFF3);
    xl(2'd2, 32'h1000_0000, 32'h3000_0000, 32'hF800_0000, "R10 win2 wrap");
    xl(2'd2, 32'h07FF_FFFF, 32'h37FF_FFFF, 32'hFFFF_FFFF, "R10 win2 last");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_xlat();
    t_timing();
    t_sizes();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule